// File: doc/BRIEF.md
# Transmit power ramp sequencer

This block frames one serial transmit burst with the enable strobes that a power amplifier and a modulator need. A start request begins the burst. The block then raises three ramp phases one after another, opens a head interval during which the data line carries a fixed default bit, and signals the serializer with a ready pulse. It waits for the serializer's last-bit indication and runs a drop interval, again on the default bit. After that it lowers the phases in reverse order and returns to idle.

Coarse delays are programmable counts of bit periods. One bit period is `BIT_DIV` sample-clock cycles, and the sample clock is `clk`. Each gap also carries a fixed fine offset of 2 sample cycles. A lead of 4 cycles, a tail of 7 cycles and a power-on lag of 3 cycles are fixed. The internal signals drive three control pins through a routing select, per-pin force bits and programmable polarity, and an inverted copy of the command pin is also provided. All configuration inputs are held stable while a burst is running.

Top module: `tx_ramp_sequencer`

## Requirements
- R1: After reset the block is idle. `cmd_o`, `ready_o` and `dflt_bit_o` are low, `cmd_n_o` is high, and `pa_en_o` and `mod_en_o` equal their inversion bits when no force bit is set.
- R2: A start sampled while idle makes the transmit-state signal high in the next cycle. Phase 1 rises 4 cycles after that. A start sampled during a burst, including the burst's last cycle, is ignored.
- R3: Phase 2 rises gap1*BIT_DIV+2 cycles after phase 1 rises, and phase 3 rises gap2*BIT_DIV+2 cycles after phase 2. On ramp-down, phase 2 falls gap3*BIT_DIV+2 cycles after phase 3 falls, and phase 1 falls gap4*BIT_DIV+2 cycles after phase 2 falls. A gap count of 0 gives exactly 2 cycles.
- R4: The head interval starts when phase 3 rises and lasts head*BIT_DIV cycles, or 1 cycle when the head count is 0. During it `dflt_bit_o` is high. `ready_o` is high for exactly the one cycle after the head interval ends.
- R5: After the ready pulse the block waits for `last_bit_i` for as long as needed. The drop interval starts in the cycle after `last_bit_i` is sampled and lasts drop*BIT_DIV cycles, or 1 cycle for a count of 0. During it `dflt_bit_o` is high, and phase 3 falls when it ends. `last_bit_i` has no effect at any other time.
- R6: The transmit-state signal falls 7 cycles after phase 1 falls. From that cycle on, a new start is accepted.
- R7: The power-on signal is phase 2 delayed by 3 cycles, on both its rising and its falling edge.
- R8: With `route_sel_i`=0, `cmd_o` follows the transmit-state signal, `pa_en_o` follows the power-on signal and `mod_en_o` follows phase 3.
- R9: With `route_sel_i`=1, `cmd_o` follows phase 1, `pa_en_o` follows phase 2 and `mod_en_o` follows phase 3.
- R10: Each bit of `force_i` (bit 0 command, bit 1 PA enable, bit 2 modulator) is ORed into its pin's source before polarity is applied. `pa_inv_i` inverts `pa_en_o`, `mod_inv_i` inverts `mod_en_o`, and `cmd_n_o` is always the complement of `cmd_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Burst start request |
| last_bit_i | input | 1 | Serializer has sent its last payload bit |
| gap1_i | input | GAP_W | Gap count from phase 1 rise to phase 2 rise |
| gap2_i | input | GAP_W | Gap count from phase 2 rise to phase 3 rise |
| gap3_i | input | GAP_W | Gap count from phase 3 fall to phase 2 fall |
| gap4_i | input | GAP_W | Gap count from phase 2 fall to phase 1 fall |
| head_i | input | GAP_W | Head interval in bit periods |
| drop_i | input | GAP_W | Drop interval in bit periods |
| route_sel_i | input | 1 | Pin routing select |
| pa_inv_i | input | 1 | Invert the PA enable pin |
| mod_inv_i | input | 1 | Invert the modulator pin |
| force_i | input | 3 | Per-pin force bits |
| ready_o | output | 1 | One-cycle pulse: serializer may send payload |
| dflt_bit_o | output | 1 | Data line must carry the default bit |
| cmd_o | output | 1 | Command pin |
| cmd_n_o | output | 1 | Inverse of the command pin |
| pa_en_o | output | 1 | PA enable pin |
| mod_en_o | output | 1 | Modulator enable pin |

## Verification
The bench counts cycles from the first cycle after the start edge, which is cycle 0. From the programmed counts and the moment it raises `last_bit_i`, it computes the cycle of every boundary. The lead ends at cycle 4, and each later boundary adds its gap, head, data or drop length. The tail ends 7 cycles after phase 1 falls, and the power-on signal lags phase 2 by 3 cycles. The pins are combinational from registered state and the configuration, so at every falling clock edge the bench compares each pin and the ready and default-bit outputs with the expected values for that cycle index. Stray starts and stray last-bit pulses are driven in phases where they must be ignored, and the timeline that follows shows whether they were.

// File: rtl/txr_pkg.sv
`timescale 1ns/1ps
package txr_pkg;
    localparam int LEAD_CYC  = 4;
    localparam int TAIL_CYC  = 7;
    localparam int GAP_FINE  = 2;
    localparam int PA_LAG    = 3;
    localparam int PIN_COUNT = 3;

    typedef enum logic [3:0] {
        ST_IDLE, ST_LEAD, ST_GAP1, ST_GAP2, ST_HEAD,
        ST_DATA, ST_DROP, ST_GAP3, ST_GAP4, ST_TAIL
    } txr_state_e;
endpackage

// File: rtl/txr_phase_fsm.sv
`timescale 1ns/1ps
module txr_phase_fsm
    import txr_pkg::*;
#(
    parameter int GAP_W   = 8,
    parameter int BIT_DIV = 20,
    localparam int CNT_W  = $clog2(((2 ** GAP_W) * BIT_DIV) + 8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             last_bit_i,
    input  logic [GAP_W-1:0] gap1_i,
    input  logic [GAP_W-1:0] gap2_i,
    input  logic [GAP_W-1:0] gap3_i,
    input  logic [GAP_W-1:0] gap4_i,
    input  logic [GAP_W-1:0] head_i,
    input  logic [GAP_W-1:0] drop_i,
    output logic             txs_o,
    output logic             ph1_o,
    output logic             ph2_o,
    output logic             ph3_o,
    output logic             dflt_o,
    output logic             ready_o
);
    typedef struct packed {
        txr_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             rdy;
    } seq_t;

    seq_t seq_d, seq_q;

    // load value for a gap: count bit periods plus the fixed fine offset, minus one
    function automatic logic [CNT_W-1:0] gap_load(input logic [GAP_W-1:0] g);
        return CNT_W'(g) * CNT_W'(BIT_DIV) + CNT_W'(GAP_FINE - 1);
    endfunction

    // load value for head/drop: whole bit periods, a zero count still takes one cycle
    function automatic logic [CNT_W-1:0] span_load(input logic [GAP_W-1:0] n);
        return (n == '0) ? '0 : CNT_W'(n) * CNT_W'(BIT_DIV) - CNT_W'(1);
    endfunction

    always_comb begin
        seq_d     = seq_q;
        seq_d.rdy = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st  = ST_LEAD;
                    seq_d.cnt = CNT_W'(LEAD_CYC - 1);
                end
            end
            ST_DATA: begin
                if (last_bit_i) begin
                    seq_d.st  = ST_DROP;
                    seq_d.cnt = span_load(drop_i);
                end
            end
            default: begin
                if (seq_q.cnt != '0) begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end else begin
                    case (seq_q.st)
                        ST_LEAD: begin seq_d.st = ST_GAP1; seq_d.cnt = gap_load(gap1_i);   end
                        ST_GAP1: begin seq_d.st = ST_GAP2; seq_d.cnt = gap_load(gap2_i);   end
                        ST_GAP2: begin seq_d.st = ST_HEAD; seq_d.cnt = span_load(head_i);  end
                        ST_HEAD: begin seq_d.st = ST_DATA; seq_d.rdy = 1'b1;               end
                        ST_DROP: begin seq_d.st = ST_GAP3; seq_d.cnt = gap_load(gap3_i);   end
                        ST_GAP3: begin seq_d.st = ST_GAP4; seq_d.cnt = gap_load(gap4_i);   end
                        ST_GAP4: begin seq_d.st = ST_TAIL; seq_d.cnt = CNT_W'(TAIL_CYC - 1); end
                        default: begin seq_d.st = ST_IDLE; seq_d.cnt = '0;                 end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, cnt: '0, rdy: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign txs_o   = (seq_q.st != ST_IDLE);
    assign ph1_o   = seq_q.st inside {ST_GAP1, ST_GAP2, ST_HEAD, ST_DATA, ST_DROP, ST_GAP3, ST_GAP4};
    assign ph2_o   = seq_q.st inside {ST_GAP2, ST_HEAD, ST_DATA, ST_DROP, ST_GAP3};
    assign ph3_o   = seq_q.st inside {ST_HEAD, ST_DATA, ST_DROP};
    assign dflt_o  = seq_q.st inside {ST_HEAD, ST_DROP};
    assign ready_o = seq_q.rdy;

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!txs_o && start_i) |=> (txs_o && !ph1_o));

    // R2
    lead_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph1_o) |-> ($past(txs_o, 4) && !$past(txs_o, 5)));

    // R3
    ramp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ph2_o) |-> ph1_o) and ($fell(ph1_o) |-> (!ph2_o && !ph3_o)));

    // R4
    ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);

    // R5
    drop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ph3_o) |-> $past(dflt_o));

    // R6
    tail_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txs_o) |-> ($past(ph1_o, 8) && !$past(ph1_o, 7)));
endmodule

// File: rtl/txr_pa_lag.sv
`timescale 1ns/1ps
module txr_pa_lag #(
    parameter int LAG = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ph2_i,
    output logic pwr_o
);
    logic [LAG-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[LAG-2:0], ph2_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end

    assign pwr_o = sr_q[LAG-1];

    // R7
    pa_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pwr_o) |-> $past(ph2_i, 3)) and ($fell(pwr_o) |-> !$past(ph2_i, 3)));
endmodule

// File: rtl/txr_pin_map.sv
`timescale 1ns/1ps
module txr_pin_map
    import txr_pkg::*;
(
    input  logic                 txs_i,
    input  logic                 pwr_i,
    input  logic                 ph1_i,
    input  logic                 ph2_i,
    input  logic                 ph3_i,
    input  logic                 route_sel_i,
    input  logic [PIN_COUNT-1:0] force_i,
    input  logic [PIN_COUNT-1:0] inv_i,
    output logic [PIN_COUNT-1:0] pin_o
);
    logic [PIN_COUNT-1:0] src;

    always_comb begin
        src[0] = route_sel_i ? ph1_i : txs_i;
        src[1] = route_sel_i ? ph2_i : pwr_i;
        src[2] = ph3_i;
    end

    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
        assign pin_o[i] = (src[i] | force_i[i]) ^ inv_i[i];
    end
endmodule

// File: rtl/tx_ramp_sequencer.sv
`timescale 1ns/1ps
module tx_ramp_sequencer
    import txr_pkg::*;
#(
    parameter int GAP_W   = 8,
    parameter int BIT_DIV = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             last_bit_i,
    input  logic [GAP_W-1:0] gap1_i,
    input  logic [GAP_W-1:0] gap2_i,
    input  logic [GAP_W-1:0] gap3_i,
    input  logic [GAP_W-1:0] gap4_i,
    input  logic [GAP_W-1:0] head_i,
    input  logic [GAP_W-1:0] drop_i,
    input  logic             route_sel_i,
    input  logic             pa_inv_i,
    input  logic             mod_inv_i,
    input  logic [2:0]       force_i,
    output logic             ready_o,
    output logic             dflt_bit_o,
    output logic             cmd_o,
    output logic             cmd_n_o,
    output logic             pa_en_o,
    output logic             mod_en_o
);
    logic txs, ph1, ph2, ph3, pwr;
    logic [PIN_COUNT-1:0] pins;

    txr_phase_fsm #(.GAP_W(GAP_W), .BIT_DIV(BIT_DIV)) i_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .last_bit_i(last_bit_i),
        .gap1_i(gap1_i), .gap2_i(gap2_i), .gap3_i(gap3_i), .gap4_i(gap4_i),
        .head_i(head_i), .drop_i(drop_i),
        .txs_o(txs), .ph1_o(ph1), .ph2_o(ph2), .ph3_o(ph3),
        .dflt_o(dflt_bit_o), .ready_o(ready_o)
    );

    txr_pa_lag #(.LAG(PA_LAG)) i_lag (
        .clk(clk), .rst_n(rst_n), .ph2_i(ph2), .pwr_o(pwr)
    );

    txr_pin_map i_map (
        .txs_i(txs), .pwr_i(pwr), .ph1_i(ph1), .ph2_i(ph2), .ph3_i(ph3),
        .route_sel_i(route_sel_i), .force_i(force_i),
        .inv_i({mod_inv_i, pa_inv_i, 1'b0}), .pin_o(pins)
    );

    assign cmd_o    = pins[0];
    assign cmd_n_o  = ~pins[0];
    assign pa_en_o  = pins[1];
    assign mod_en_o = pins[2];

    // R7
    pwr_inside_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr |-> txs);
endmodule

// File: tb/test_tx_ramp_sequencer.sv
`timescale 1ns/1ps
module test_tx_ramp_sequencer;
    localparam int GW = 8;
    localparam int BD = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, last_bit = 1'b0;
    logic [GW-1:0] g1 = '0, g2 = '0, g3 = '0, g4 = '0, hd = '0, dr = '0;
    logic route = 1'b0, pinv = 1'b0, minv = 1'b0;
    logic [2:0] frc = '0;
    logic ready, dflt, cmd, cmd_n, pa, md;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tx_ramp_sequencer #(.GAP_W(GW), .BIT_DIV(BD)) i_tx_ramp_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start), .last_bit_i(last_bit),
        .gap1_i(g1), .gap2_i(g2), .gap3_i(g3), .gap4_i(g4),
        .head_i(hd), .drop_i(dr), .route_sel_i(route),
        .pa_inv_i(pinv), .mod_inv_i(minv), .force_i(frc),
        .ready_o(ready), .dflt_bit_o(dflt), .cmd_o(cmd), .cmd_n_o(cmd_n),
        .pa_en_o(pa), .mod_en_o(md)
    );

    task automatic cmp(input string tag, input int t, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle=%0d actual=%0b expected=%0b", tag, t, act, exp);
        end
    endtask

    function automatic int gap_len(input int g);
        return g * BD + 2;
    endfunction

    function automatic int span_len(input int n);
        return (n == 0) ? 1 : n * BD;
    endfunction

    task automatic burst(input int a1, input int a2, input int a3, input int a4,
                         input int ah, input int ad, input int len,
                         input bit rt, input bit pi, input bit mi, input logic [2:0] fc,
                         input bit late_start);
        int b1, b2, b3, b4, b5, b6, b7, b8, b9;
        g1 = GW'(a1); g2 = GW'(a2); g3 = GW'(a3); g4 = GW'(a4);
        hd = GW'(ah); dr = GW'(ad);
        route = rt; pinv = pi; minv = mi; frc = fc;
        b1 = 4;                 // R2 lead
        b2 = b1 + gap_len(a1);  // R3
        b3 = b2 + gap_len(a2);
        b4 = b3 + span_len(ah); // R4 head end
        b5 = b4 + len;          // R5 drop begins
        b6 = b5 + span_len(ad);
        b7 = b6 + gap_len(a3);
        b8 = b7 + gap_len(a4);
        b9 = b8 + 7;            // R6 tail
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t <= b9 + 2; t++) begin
            logic e_txs, e_p1, e_p2, e_p3, e_pw, e_cmd, e_pa, e_md;
            e_txs = (t < b9);
            e_p1  = (t >= b1) && (t < b8);
            e_p2  = (t >= b2) && (t < b7);
            e_p3  = (t >= b3) && (t < b6);
            e_pw  = (t >= b2 + 3) && (t < b7 + 3);
            e_cmd = (rt ? e_p1 : e_txs) | fc[0];
            e_pa  = ((rt ? e_p2 : e_pw) | fc[1]) ^ pi;
            e_md  = (e_p3 | fc[2]) ^ mi;
            cmp("R4 ready pulse", t, ready, (t == b4));
            cmp("R5 default bit (head R4 / drop R5)", t, dflt,
                ((t >= b3) && (t < b4)) || ((t >= b5) && (t < b6)));
            cmp(rt ? "R9 cmd pin (R2/R3/R6)" : "R8 cmd pin (R2/R6)", t, cmd, e_cmd);
            cmp("R10 cmd_n complement", t, cmd_n, ~e_cmd);
            cmp(rt ? "R9 pa pin (R3)" : "R8 pa pin (R7)", t, pa, e_pa);
            cmp("R10 mod pin polarity/force (R3/R5)", t, md, e_md);
            // stimulus for the next edge
            last_bit = (t == b4 + len - 1) || (t == 1) || (t == b9); // R5 strays at t=1 and idle
            start    = (t == b2) || (late_start && (t == b9 - 1));  // R2 ignored while busy
            @(negedge clk);
        end
        last_bit = 1'b0;
        start = 1'b0;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4417);
        repeat (2) @(negedge clk);
        // R1 reset state
        cmp("R1 ready idle", -1, ready, 1'b0);
        cmp("R1 default idle", -1, dflt, 1'b0);
        cmp("R1 cmd idle", -1, cmd, 1'b0);
        cmp("R1 cmd_n idle", -1, cmd_n, 1'b1);
        cmp("R1 pa idle", -1, pa, 1'b0);
        cmp("R1 mod idle", -1, md, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners: all-zero counts, heavy counts, routing, polarity, force
        burst(0, 0, 0, 0, 0, 0, 1, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1);
        burst(0, 0, 0, 0, 0, 0, 1, 1'b1, 1'b1, 1'b1, 3'b000, 1'b0);
        burst(3, 1, 2, 4, 2, 3, 5, 1'b1, 1'b0, 1'b1, 3'b000, 1'b1);
        burst(1, 2, 1, 1, 1, 1, 2, 1'b0, 1'b1, 1'b0, 3'b101, 1'b0);
        burst(2, 0, 1, 0, 1, 0, 3, 1'b0, 1'b0, 1'b0, 3'b010, 1'b0);
        // constrained random bursts
        for (int k = 0; k < 24; k++) begin
            int r;
            r = int'($urandom_range(0, 7));
            burst(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                  int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                  int'($urandom_range(0, 2)), int'($urandom_range(0, 2)),
                  int'($urandom_range(1, 6)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)),
                  (r == 0) ? 3'($urandom_range(1, 7)) : 3'b000,
                  1'($urandom_range(0, 1)));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule